// File: doc/BRIEF.md
# Dual-Clock Almost-Full Flag Logic

This block holds the write-side fill status of a 64-entry, two-clock FIFO whose entries are 36 bits wide. It counts writes in the write clock domain and reads in the read clock domain. It brings the read progress into the write domain and drives an active-low almost-full flag that is timed to the write clock. The FIFO storage, the data paths and the empty-side status are handled elsewhere. The read side is expected to issue reads only while data is present.

The almost-full threshold is set by an offset value X. X is fixed while the write-side reset is held and is taken from a 2-bit preset select. The flag drops on the same write-clock edge as the write that reaches the threshold. When reads free space, the flag does not rise at once. It rises on the second write-clock edge after the read pointer moves, because the read pointer crosses into the write domain as Gray code through two flops.

Top module: `afull_flag_top`

## Requirements
- R1: While reset is held, and after it is released with no traffic, afull_n is 1 and wr_level is 0.
- R2: The offset X is loaded while wr_rst is high from ofs_sel. Code 0 gives X=4, 1 gives X=8, 2 gives X=16 and 3 gives X=32.
- R3: Changes on ofs_sel while wr_rst is low have no effect on the threshold.
- R4: afull_n is 0 whenever wr_level is at least 64-X. It is 1 whenever wr_level is 63-X or less, once all reads have been synchronized.
- R5: afull_n can only fall as the result of a write. It falls directly after the write-clock edge that accepts the write bringing wr_level up to 64-X.
- R6: After a read edge, the flag and the level take up the freed entry on the second rising write-clock edge that follows the read. At the first such edge they are still unchanged.
- R7: A write requested while wr_level is 64 is ignored, and wr_level never exceeds 64.
- R8: The read pointer that crosses clock domains changes in at most one bit per read-clock edge (Gray code).
- R9: wr_level equals the accepted writes minus the reads that have passed through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_inc | input | 1 | One word written this write-clock cycle |
| ofs_sel | input | 2 | Preset offset select, sampled during wr_rst |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_inc | input | 1 | One word read this read-clock cycle |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| wr_level | output | 7 | Write-domain view of the stored word count |

## Verification
A wrong offset register or a wrong count shows up as a threshold that is off by some words. The flag then flips one write early or late, at the edge where the write is accepted. A broken synchronizer path shows up in the read timing: the flag or the level moves at the first write edge after a read instead of the second, or never moves at all, so it is visible within two write cycles. A missing overflow guard shows as a level above 64 straight after the extra write.

// File: rtl/afull_pkg.sv
package afull_pkg;

    localparam int DEPTH = 64;
    localparam int PTR_W = $clog2(DEPTH) + 1;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [1:0] {
        OFS_4  = 2'd0,
        OFS_8  = 2'd1,
        OFS_16 = 2'd2,
        OFS_32 = 2'd3
    } ofs_sel_e;

    typedef struct packed {
        ptr_t bin;
        ptr_t gray;
    } ptr_pair_t;

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic ptr_t preset_offset(input ofs_sel_e sel);
        ptr_t x;
        case (sel)
            OFS_4:   x = ptr_t'(4);
            OFS_8:   x = ptr_t'(8);
            OFS_16:  x = ptr_t'(16);
            default: x = ptr_t'(32);
        endcase
        return x;
    endfunction

endpackage

// File: rtl/afull_rd_ptr.sv
module afull_rd_ptr
    import afull_pkg::*;
(
    input  logic rd_clk,
    input  logic rd_rst,
    input  logic rd_inc,
    output ptr_t rd_gray
);

    ptr_pair_t cur_q;
    ptr_t      bin_nxt;

    always_comb begin
        bin_nxt = cur_q.bin + ptr_t'(rd_inc);
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            cur_q <= '0;
        end else begin
            cur_q.bin  <= bin_nxt;
            cur_q.gray <= bin2gray(bin_nxt);
        end
    end

    assign rd_gray = cur_q.gray;

    AST_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !$past(rd_rst) |-> $onehot0(rd_gray ^ $past(rd_gray))) // R8
        else $error("read pointer changed more than one bit");

endmodule

// File: rtl/afull_sync.sv
module afull_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/afull_wr_ctl.sv
module afull_wr_ctl
    import afull_pkg::*;
(
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic       wr_inc,
    input  logic [1:0] ofs_sel,
    input  ptr_t       rd_gray_s,
    output logic       afull_n,
    output ptr_t       wr_level
);

    ptr_t wr_bin_q;
    ptr_t ofs_q;
    ptr_t rd_bin_s;
    ptr_t limit;
    logic full;

    always_comb begin
        rd_bin_s = gray2bin(rd_gray_s);
        wr_level = wr_bin_q - rd_bin_s;
        full     = (wr_level == ptr_t'(DEPTH));
        limit    = ptr_t'(DEPTH) - ofs_q;
        afull_n  = !(wr_level >= limit);
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_bin_q <= '0;
            ofs_q    <= preset_offset(ofs_sel_e'(ofs_sel));
        end else if (wr_inc && !full) begin
            wr_bin_q <= wr_bin_q + ptr_t'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_level <= ptr_t'(DEPTH)) // R7
        else $error("level above depth");

    AST_PTR_STEP: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!$past(wr_rst) && !$stable(wr_bin_q)) |-> (wr_bin_q == $past(wr_bin_q) + ptr_t'(1))) // R9
        else $error("write pointer jumped");

    AST_OFS_HOLD: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !$past(wr_rst) |-> $stable(ofs_q)) // R3
        else $error("offset changed outside reset");

    AST_FALL_BY_WRITE: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!$past(wr_rst) && $fell(afull_n)) |-> $past(wr_inc)) // R5
        else $error("flag fell without a write");

    AST_RISE_BY_SYNC: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!$past(wr_rst) && $rose(afull_n)) |-> !$stable(rd_gray_s)) // R6
        else $error("flag rose without synchronized read");

endmodule

// File: rtl/afull_flag_top.sv
module afull_flag_top
    import afull_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_inc,
    input  logic [1:0]       ofs_sel,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_inc,
    output logic             afull_n,
    output logic [PTR_W-1:0] wr_level
);

    ptr_t rd_gray;
    ptr_t rd_gray_s;

    afull_rd_ptr u_rd_ptr (
        .rd_clk  (rd_clk),
        .rd_rst  (rd_rst),
        .rd_inc  (rd_inc),
        .rd_gray (rd_gray)
    );

    afull_sync #(
        .W      (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_rd_sync (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rd_gray),
        .q   (rd_gray_s)
    );

    afull_wr_ctl u_wr_ctl (
        .wr_clk    (wr_clk),
        .wr_rst    (wr_rst),
        .wr_inc    (wr_inc),
        .ofs_sel   (ofs_sel),
        .rd_gray_s (rd_gray_s),
        .afull_n   (afull_n),
        .wr_level  (wr_level)
    );

    AST_RESET_FLAG: assert property (@(posedge wr_clk)
        $past(wr_rst) |-> (afull_n && wr_level == '0)) // R1
        else $error("flag or level wrong after reset");

endmodule

// File: tb/afull_flag_top_bench.sv
module afull_flag_top_bench;

    logic       wr_clk = 1'b0;
    logic       wr_rst = 1'b1;
    logic       wr_inc = 1'b0;
    logic [1:0] ofs_sel = 2'd0;
    logic       rd_clk = 1'b0;
    logic       rd_rst = 1'b1;
    logic       rd_inc = 1'b0;
    logic       afull_n;
    logic [6:0] wr_level;

    int total = 0;
    int bad   = 0;

    afull_flag_top u_afull_flag_top (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_inc   (wr_inc),
        .ofs_sel  (ofs_sel),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_inc   (rd_inc),
        .afull_n  (afull_n),
        .wr_level (wr_level)
    );

    always #10 wr_clk = ~wr_clk;

    typedef struct packed {
        logic [1:0] sel;
        logic [6:0] n;
        logic       flag;
    } vec_t;

    // R2 / R4: threshold 64-X with X = 4,8,16,32 for codes 0..3
    localparam vec_t VECS [8] = '{
        '{2'd0, 7'd59, 1'b1},
        '{2'd0, 7'd60, 1'b0},
        '{2'd1, 7'd55, 1'b1},
        '{2'd1, 7'd56, 1'b0},
        '{2'd2, 7'd47, 1'b1},
        '{2'd2, 7'd48, 1'b0},
        '{2'd3, 7'd31, 1'b1},
        '{2'd3, 7'd32, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        ofs_sel = sel;
        wr_rst  = 1'b1;
        rd_rst  = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge wr_clk);
            #2 rd_clk = 1'b1;
            #2 rd_clk = 1'b0;
        end
        @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
    endtask

    task automatic wr_words(input int n);
        wr_inc = 1'b1;
        repeat (n) @(negedge wr_clk);
        wr_inc = 1'b0;
    endtask

    task automatic rd_one();
        #2 rd_inc = 1'b1;
        #1 rd_clk = 1'b1;
        #2 rd_clk = 1'b0;
        rd_inc = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(2'd0);
        chk("R1 flag after reset", afull_n, 1);
        chk("R1 level after reset", wr_level, 0);

        // R2 R4 R5: table of threshold points
        for (int v = 0; v < 8; v++) begin
            do_reset(VECS[v].sel);
            wr_words(int'(VECS[v].n));
            chk($sformatf("R2 R4 R5 flag vec %0d", v), afull_n, int'(VECS[v].flag));
            chk($sformatf("R9 level vec %0d", v), wr_level, int'(VECS[v].n));
        end

        // R3: select changed after reset is ignored
        do_reset(2'd0);
        ofs_sel = 2'd3;
        wr_words(32);
        chk("R3 flag at 32 with late select", afull_n, 1);
        wr_words(27);
        chk("R3 flag at 59", afull_n, 1);
        wr_words(1);
        chk("R3 flag at 60", afull_n, 0);

        // R7: overflow guard
        do_reset(2'd3);
        wr_words(70);
        chk("R7 level capped", wr_level, 64);
        chk("R7 flag at full", afull_n, 0);
        rd_one();
        @(negedge wr_clk);
        @(negedge wr_clk);
        chk("R9 level after read", wr_level, 63);
        wr_words(2);
        chk("R7 level capped again", wr_level, 64);

        // R6 R4: release timing at the threshold, X=4
        do_reset(2'd0);
        wr_words(64);
        for (int r = 0; r < 4; r++) begin
            rd_one();
            @(negedge wr_clk);
            @(negedge wr_clk);
        end
        chk("R4 level at 60", wr_level, 60);
        chk("R4 flag at 60", afull_n, 0);
        rd_one();
        @(negedge wr_clk);
        chk("R6 flag after first edge", afull_n, 0);
        chk("R6 level after first edge", wr_level, 60);
        @(negedge wr_clk);
        chk("R6 flag after second edge", afull_n, 1);
        chk("R9 level after second edge", wr_level, 59);
        wr_words(1);
        chk("R5 flag falls on write", afull_n, 0);

        // R1: reset from a filled state
        do_reset(2'd1);
        chk("R1 flag after refill reset", afull_n, 1);
        chk("R1 level after refill reset", wr_level, 0);

        // R8: several reads in a row reach the level
        wr_words(10);
        for (int r = 0; r < 5; r++) begin
            rd_one();
            @(negedge wr_clk);
        end
        @(negedge wr_clk);
        @(negedge wr_clk);
        chk("R8 R9 level after five reads", wr_level, 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule